// File: doc/BRIEF.md
# Chained-Block Unwrapper with Signature Gate

This block sits downstream of a block-cipher decryption core in a firmware-update receiver. The decryption core hands it, one block at a time, the raw decrypted output together with the ciphertext that produced it. The block removes the chaining by XORing the raw output with a chaining register. For the first block after reset or after a restart, that register holds a stored initialization vector. For every later block, it holds the previous block's ciphertext.

Each recovered 128-bit plaintext block is taken to be a 32-bit fixed secret signature followed by 96 bits of payload. The last chunk of an image may be filled out with random padding, and the block passes that padding through unchanged. The signature is compared as one whole word. A block that matches has its payload presented on a 96-bit output. A block that does not match is dropped, and the mismatch is not reported on any output.

Both sides use valid/ready handshakes. A new block is taken only when no accepted payload is waiting for delivery.

Top module: `cbc_unchain_sigchk`

## Requirements
- R1: While reset is asserted and after it is released, out_valid is 0, in_ready is 1, and the chaining register holds the parameter INIT_VECTOR.
- R2: The first block accepted after reset is recovered as in_plain_raw XOR INIT_VECTOR.
- R3: Each later block is recovered as in_plain_raw XOR the in_cipher of the previously accepted block.
- R4: The chaining register takes the ciphertext of every accepted block, whether that block's signature matched or not.
- R5: The signature is bits [127:96] of the recovered block, with byte 0 in the most significant position. It is compared against SIG_VALUE as a single whole-word equality. A difference in any byte drops the block, and no output shows that the block was dropped.
- R6: The payload is bits [95:0] of the recovered block. It is delivered bit for bit unchanged, padding included.
- R7: A matching block raises out_valid on the clock edge after the edge that accepted it. out_valid and out_payload then hold until out_ready is seen high. With out_ready held high, out_valid lasts exactly one cycle.
- R8: in_ready is low while an undelivered payload is held, and low during any cycle in which restart is high.
- R9: A cycle with restart high reloads the chaining register from INIT_VECTOR, so the next block accepted is XORed with it.
- R10: Payloads are delivered in the same order as their blocks were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| restart | input | 1 | Reloads the chaining register from the initialization vector |
| in_valid | input | 1 | Decrypted block and ciphertext are present |
| in_ready | output | 1 | Block can take a new input this cycle |
| in_plain_raw | input | 128 | Raw decryption output for the block |
| in_cipher | input | 128 | Ciphertext of the same block |
| out_valid | output | 1 | Accepted payload is present |
| out_ready | input | 1 | Downstream takes the payload |
| out_payload | output | 96 | The 12 payload bytes of an accepted block |

## Verification
A payload is due on out_valid exactly one edge after the edge that accepted its block. in_ready drops in the same cycle that out_valid rises, because in_ready is derived without a register from the held payload and from restart. The bench keeps a behavioural model that applies the same one-edge latency. At every falling clock edge, between updates, it compares in_ready, out_valid and out_payload against that model. A queue of delivered payloads is also checked against the expected list after each scenario. That queue is how dropped blocks, chaining through rejected blocks, and delivery order are observed.

// File: rtl/cbc_unchain_pkg.sv
package cbc_unchain_pkg;
   localparam int unsigned DEF_BYTE_W      = 8;
   localparam int unsigned DEF_BLOCK_BYTES = 16;
   localparam int unsigned DEF_SIG_BYTES   = 4;
   localparam logic [127:0] DEF_INIT_VECTOR = 128'h0f1e2d3c_4b5a6978_8796a5b4_c3d2e1f0;
   localparam logic [31:0]  DEF_SIG_VALUE   = 32'hc0de_f00d;
endpackage

// File: rtl/cbc_chain_xor.sv
module cbc_chain_xor #(
   parameter int unsigned BYTE_W      = 8,
   parameter int unsigned BLOCK_BYTES = 16,
   parameter logic [BLOCK_BYTES*BYTE_W-1:0] INIT_VECTOR = '0
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          restart,
   input  logic                          load,
   input  logic [BLOCK_BYTES*BYTE_W-1:0] raw,
   input  logic [BLOCK_BYTES*BYTE_W-1:0] cipher,
   output logic [BLOCK_BYTES*BYTE_W-1:0] plain
);
   localparam int unsigned BLOCK_W = BLOCK_BYTES * BYTE_W;

   logic [BLOCK_W-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (!rst_n || restart) begin
         chain_q <= INIT_VECTOR;
      end else if (load) begin
         chain_q <= cipher;
      end
   end

   for (genvar b = 0; b < BLOCK_BYTES; b++) begin : g_byte
      assign plain[b*BYTE_W +: BYTE_W] = raw[b*BYTE_W +: BYTE_W] ^ chain_q[b*BYTE_W +: BYTE_W];
   end
endmodule

// File: rtl/cbc_sig_match.sv
module cbc_sig_match #(
   parameter int unsigned BYTE_W       = 8,
   parameter int unsigned SIG_BYTES    = 4,
   parameter bit          CMP_PER_BYTE = 1'b0,
   parameter logic [SIG_BYTES*BYTE_W-1:0] SIG_VALUE = '0
) (
   input  logic [SIG_BYTES*BYTE_W-1:0] sig_field,
   output logic                        match
);
   if (CMP_PER_BYTE) begin : g_bytewise
      logic [SIG_BYTES-1:0] byte_eq;
      for (genvar b = 0; b < SIG_BYTES; b++) begin : g_eq
         assign byte_eq[b] = (sig_field[b*BYTE_W +: BYTE_W] == SIG_VALUE[b*BYTE_W +: BYTE_W]);
      end
      assign match = &byte_eq;
   end else begin : g_wide
      assign match = (sig_field == SIG_VALUE);
   end
endmodule

// File: rtl/cbc_out_stage.sv
module cbc_out_stage #(
   parameter int unsigned PAY_W = 96
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic [PAY_W-1:0] pay_in,
   input  logic             out_ready,
   output logic             out_valid,
   output logic [PAY_W-1:0] out_payload
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_payload <= '0;
      end else if (take) begin
         out_valid   <= 1'b1;
         out_payload <= pay_in;
      end else if (out_ready) begin
         out_valid   <= 1'b0;
      end
   end
endmodule

// File: rtl/cbc_unchain_sigchk.sv
module cbc_unchain_sigchk
   import cbc_unchain_pkg::*;
#(
   parameter int unsigned BYTE_W       = DEF_BYTE_W,
   parameter int unsigned BLOCK_BYTES  = DEF_BLOCK_BYTES,
   parameter int unsigned SIG_BYTES    = DEF_SIG_BYTES,
   parameter bit          CMP_PER_BYTE = 1'b0,
   parameter logic [BLOCK_BYTES*BYTE_W-1:0] INIT_VECTOR = DEF_INIT_VECTOR,
   parameter logic [SIG_BYTES*BYTE_W-1:0]   SIG_VALUE   = DEF_SIG_VALUE
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         restart,
   input  logic         in_valid,
   output logic         in_ready,
   input  logic [127:0] in_plain_raw,
   input  logic [127:0] in_cipher,
   output logic         out_valid,
   input  logic         out_ready,
   output logic [95:0]  out_payload
);
   localparam int unsigned BLOCK_W = BLOCK_BYTES * BYTE_W;
   localparam int unsigned SIG_W   = SIG_BYTES * BYTE_W;
   localparam int unsigned PAY_W   = BLOCK_W - SIG_W;

   if (BLOCK_W != 128 || PAY_W != 96) begin : g_bad_shape
      $error("block must be 128 bits with a 96-bit payload");
   end
   if (SIG_BYTES == 0 || SIG_BYTES >= BLOCK_BYTES) begin : g_bad_sig
      $error("signature must be shorter than the block");
   end

   logic               accept;
   logic               sig_ok;
   logic [BLOCK_W-1:0] plain;

   assign in_ready = !out_valid && !restart;
   assign accept   = in_valid && in_ready;

   cbc_chain_xor #(
      .BYTE_W(BYTE_W), .BLOCK_BYTES(BLOCK_BYTES), .INIT_VECTOR(INIT_VECTOR)
   ) u_chain (
      .clk(clk), .rst_n(rst_n), .restart(restart), .load(accept),
      .raw(in_plain_raw), .cipher(in_cipher), .plain(plain)
   );

   cbc_sig_match #(
      .BYTE_W(BYTE_W), .SIG_BYTES(SIG_BYTES), .CMP_PER_BYTE(CMP_PER_BYTE), .SIG_VALUE(SIG_VALUE)
   ) u_sig (
      .sig_field(plain[BLOCK_W-1 -: SIG_W]), .match(sig_ok)
   );

   cbc_out_stage #(.PAY_W(PAY_W)) u_out (
      .clk(clk), .rst_n(rst_n), .take(accept && sig_ok),
      .pay_in(plain[PAY_W-1:0]), .out_ready(out_ready),
      .out_valid(out_valid), .out_payload(out_payload)
   );
endmodule

// File: rtl/cbc_unchain_sigchk_chk.sv
module cbc_unchain_sigchk_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        restart,
   input logic        in_valid,
   input logic        in_ready,
   input logic        out_valid,
   input logic        out_ready,
   input logic [95:0] out_payload
);
   // R1
   reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);
   // R8
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> !in_ready);
   // R8
   restart_block_chk: assert property (@(posedge clk) disable iff (!rst_n) restart |-> !in_ready);
   // R7
   hold_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_payload)));
   // R7
   rise_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> $past(in_valid && in_ready));
   // R7
   one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && !(in_valid && in_ready)) |=> !out_valid);
endmodule

bind cbc_unchain_sigchk cbc_unchain_sigchk_chk u_chk (
   .clk(clk), .rst_n(rst_n), .restart(restart), .in_valid(in_valid),
   .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
   .out_payload(out_payload)
);

// File: tb/cbc_unchain_sigchk_test.sv
module cbc_unchain_sigchk_test;
   localparam logic [127:0] IV  = 128'h0f1e2d3c_4b5a6978_8796a5b4_c3d2e1f0;
   localparam logic [31:0]  SIG = 32'hc0de_f00d;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic restart = 1'b0;
   logic in_valid = 1'b0;
   logic out_ready = 1'b1;
   logic [127:0] in_plain_raw = '0;
   logic [127:0] in_cipher = '0;
   logic in_ready, out_valid;
   logic [95:0] out_payload;

   int total = 0;
   int bad = 0;
   int cycles = 0;

   always #10 clk = ~clk;

   cbc_unchain_sigchk uut (
      .clk(clk), .rst_n(rst_n), .restart(restart), .in_valid(in_valid),
      .in_ready(in_ready), .in_plain_raw(in_plain_raw), .in_cipher(in_cipher),
      .out_valid(out_valid), .out_ready(out_ready), .out_payload(out_payload)
   );

   task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // behavioural reference
   logic         m_valid = 1'b0;
   logic [95:0]  m_pay = '0;
   logic [127:0] m_chain = IV;
   always @(posedge clk) begin
      logic acc;
      logic [127:0] p;
      if (!rst_n) begin
         m_valid = 1'b0;
         m_chain = IV;
      end else begin
         acc = in_valid && !m_valid && !restart;
         if (m_valid && out_ready) m_valid = 1'b0;
         if (restart) m_chain = IV;
         else if (acc) begin
            p = in_plain_raw ^ m_chain;
            if (p[127:96] == SIG) begin
               m_valid = 1'b1;
               m_pay   = p[95:0];
            end
            m_chain = in_cipher;
         end
      end
   end

   logic [95:0] rx_q[$];
   logic [95:0] exp_q[$];

   always @(negedge clk) begin
      if (rst_n) begin
         // R8 per-cycle ready
         check(in_ready == (!m_valid && !restart), "R8", 128'(in_ready), 128'(!m_valid && !restart));
         // R7 per-cycle valid and payload
         check(out_valid == m_valid, "R7", 128'(out_valid), 128'(m_valid));
         if (m_valid) check(out_payload == m_pay, "R6", 128'(out_payload), 128'(m_pay));
         if (out_valid && out_ready) rx_q.push_back(out_payload);
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         total++; bad++;
         $display("FAIL watchdog actual=%0d expected=<100000", cycles);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   logic [127:0] tb_chain = IV;

   task automatic send(input logic [127:0] raw, input logic [127:0] cip);
      @(negedge clk);
      in_valid = 1'b1; in_plain_raw = raw; in_cipher = cip;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic blk(input logic [31:0] sig, input logic [95:0] pay, input logic [127:0] cip, input bit good);
      send({sig, pay} ^ tb_chain, cip);
      tb_chain = cip;
      if (good) exp_q.push_back(pay);
   endtask

   task automatic expect_rx(input string req);
      repeat (3) @(negedge clk);
      check(rx_q.size() == exp_q.size(), req, 128'(rx_q.size()), 128'(exp_q.size()));
      for (int i = 0; i < exp_q.size() && i < rx_q.size(); i++)
         check(rx_q[i] == exp_q[i], req, 128'(rx_q[i]), 128'(exp_q[i]));
      rx_q.delete();
      exp_q.delete();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check(out_valid == 1'b0, "R1", 128'(out_valid), 128'(0));
      check(in_ready == 1'b1, "R1", 128'(in_ready), 128'(1));
      rst_n = 1'b1;
      @(negedge clk);
      check(in_ready == 1'b1, "R1", 128'(in_ready), 128'(1));

      // R2 first block against the vector; R6 payload incl. padding
      blk(SIG, 96'h0011_2233_4455_6677_8899_aabb, 128'hdead_beef_0102_0304_0506_0708_090a_0b0c, 1);
      expect_rx("R2");
      // R3 chained through previous ciphertext
      blk(SIG, 96'ha5a5_5a5a_ffff_0000_1234_5678, 128'h1111_2222_3333_4444_5555_6666_7777_8888, 1);
      expect_rx("R3");
      // R5 last signature byte wrong: dropped
      blk(SIG ^ 32'h0000_0001, 96'h1, 128'h9999_aaaa_bbbb_cccc_dddd_eeee_ffff_0001, 0);
      expect_rx("R5");
      // R4 next block must chain on the rejected block's ciphertext
      blk(SIG, 96'hfeed_face_cafe_babe_0bad_f00d, 128'h0123_4567_89ab_cdef_0123_4567_89ab_cdef, 1);
      expect_rx("R4");
      // R5 first signature byte wrong
      blk(SIG ^ 32'h8000_0000, 96'h2, 128'h2, 0);
      expect_rx("R5");

      // R7 back-pressure: payload held, R8 ready low
      out_ready = 1'b0;
      blk(SIG, 96'h7777_6666_5555_4444_3333_2222, 128'h3, 1);
      repeat (4) @(negedge clk);
      check(out_valid == 1'b1, "R7", 128'(out_valid), 128'(1));
      check(in_ready == 1'b0, "R8", 128'(in_ready), 128'(0));
      out_ready = 1'b1;
      expect_rx("R7");

      // R9 restart reloads the vector
      @(negedge clk); restart = 1'b1;
      @(negedge clk);
      check(in_ready == 1'b0, "R8", 128'(in_ready), 128'(0));
      restart = 1'b0;
      tb_chain = IV;
      blk(SIG, 96'h0a0b_0c0d_0e0f_1011_1213_1415, 128'h4, 1);
      expect_rx("R9");

      // R10 ordering over a burst, mix of good and bad
      blk(SIG, 96'h1, 128'h10, 1);
      blk(SIG ^ 32'h0100_0000, 96'h9, 128'h11, 0);
      blk(SIG, 96'h2, 128'h12, 1);
      blk(SIG, 96'h3, 128'h13, 1);
      expect_rx("R10");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule